// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache

This block is a cache that sits between a processor issuing 15-bit word addresses and a 32K x 12 main memory. It is direct-mapped, with 512 single-word lines. The upper six address bits form the tag and the lower nine bits select the line. Each line stores a valid flag, a tag and a 12-bit word. A read that finds its line valid with a matching tag is answered from the line. A read that misses fetches the word over a request/acknowledge memory port, hands it to the processor in the acknowledge cycle and overwrites the selected line.

Every write goes to main memory, so memory never falls behind the cache. A write whose line hits also updates the cached word. A write that misses leaves the cache unchanged. An initialize input invalidates every line in a single cycle. Two counters report the number of lookups and the number of hits, so that the hit ratio can be computed outside the block.

The processor raises `cpu_req_i` with a stable address, write flag and write data. It holds them until it sees `cpu_ready_o`, which is a one-cycle pulse that ends the access.

Top module: `wtc_cache_top`

## Requirements
- R1: The address splits as tag = `cpu_addr_i[14:9]` and line index = `cpu_addr_i[8:0]`. A lookup hits only when the indexed line is valid and its stored tag equals the address tag.
- R2: An access is accepted in an idle cycle. On a read hit, `cpu_ready_o` is high in the following cycle, `cpu_rdata_o` carries the cached word, and `mem_req_o` stays low for the whole access.
- R3: On a read miss, `mem_req_o` rises with `mem_we_o` low and `mem_addr_o` equal to the access address. All three hold until `mem_ack_i`. In the acknowledge cycle, `cpu_ready_o` is high and `cpu_rdata_o` equals `mem_rdata_i`.
- R4: A read miss replaces the indexed line with the new tag and word. A later read of the same address hits, and a later read of the evicted address misses.
- R5: Every write, hit or miss, issues a memory write with `mem_we_o` high and the access address and data. `cpu_ready_o` pulses in the acknowledge cycle.
- R6: A write hit also updates the cached word, so a later read hits and returns the written data.
- R7: A write miss does not allocate a line, so a later read of that address misses.
- R8: Reset and a one-cycle `init_i` pulse clear every valid flag. When `init_i` coincides with a read-miss acknowledge, the line is left invalid.
- R9: `acc_cnt_o` increments by one for every lookup. `hit_cnt_o` increments by one for every lookup that hits, whether a read or a write.
- R10: While in reset and right after it, `cpu_ready_o` and `mem_req_o` are low and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Invalidate all lines |
| cpu_req_i | input | 1 | Access request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 15 | Word address |
| cpu_wdata_i | input | 12 | Write data |
| cpu_rdata_o | output | 12 | Read data, valid with ready |
| cpu_ready_o | output | 1 | Access complete pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write flag |
| mem_addr_o | output | 15 | Memory word address |
| mem_wdata_o | output | 12 | Memory write data |
| mem_rdata_i | input | 12 | Memory read data |
| mem_ack_i | input | 1 | Memory acknowledge |
| hit_cnt_o | output | 16 | Lookup hits so far |
| acc_cnt_o | output | 16 | Lookups so far |

## Verification
The initialize pulse and a miss fill can land in the same clock edge, and the design has to let the clear win. The bench provokes this by raising `init_i` in the exact cycle in which it acknowledges a read miss. It then judges the result by reading the same address again and requiring a fresh memory request, where a hit would mean the fill escaped the clear. The per-cycle reference model carries its own valid, tag and data arrays, together with a sparse memory image, and checks every handshake cycle and both counters after each access.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_RD_MEM = 2'd2,
    ST_WR_MEM = 2'd3
  } wtc_state_e;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int IDX_W  = 9,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 12,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_en_i,
  input  logic              set_valid_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  // clear dominates any fill landing in the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   valid_q <= '0;
    else if (clear_i)              valid_q <= '0;
    else if (wr_en_i && set_valid_i) valid_q[idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_mem[idx_i]  <= wr_tag_i;
      data_mem[idx_i] <= wr_data_i;
    end
  end

  assign rd_valid_o = valid_q[idx_i];
  assign rd_tag_o   = tag_mem[idx_i];
  assign rd_data_o  = data_mem[idx_i];
endmodule

// File: rtl/wtc_tag_cmp.sv
module wtc_tag_cmp #(
  parameter int TAG_W = 6
) (
  input  logic             valid_i,
  input  logic [TAG_W-1:0] stored_i,
  input  logic [TAG_W-1:0] probe_i,
  output logic             hit_o
);
  logic [TAG_W-1:0] bit_eq;
  for (genvar b = 0; b < TAG_W; b++) begin : g_eq
    assign bit_eq[b] = ~(stored_i[b] ^ probe_i[b]);
  end
  assign hit_o = valid_i & (&bit_eq);
endmodule

// File: rtl/wtc_counters.sv
module wtc_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lookup_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0] acc_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_cnt_o <= '0;
      acc_cnt_o <= '0;
    end else if (lookup_i) begin
      acc_cnt_o <= acc_cnt_o + 1'b1;
      if (hit_i) hit_cnt_o <= hit_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/wtc_cache_top.sv
module wtc_cache_top #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 9,
  parameter int CNT_W  = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  acc_cnt_o
);
  import wtc_pkg::*;

  wtc_state_e        state_q, state_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic              rd_valid, hit;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              lookup, upd_en, fill_en, wr_en;
  logic [DATA_W-1:0] wr_data;

  assign a_tag = addr_q[ADDR_W-1:IDX_W];
  assign a_idx = addr_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cpu_req_i) begin
        we_q    <= cpu_we_i;
        addr_q  <= cpu_addr_i;
        wdata_q <= cpu_wdata_i;
      end
    end
  end

  always_comb begin
    state_d     = state_q;
    lookup      = 1'b0;
    upd_en      = 1'b0;
    fill_en     = 1'b0;
    cpu_ready_o = 1'b0;
    cpu_rdata_o = '0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cpu_req_i) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        lookup = 1'b1;
        if (we_q) begin
          upd_en  = hit;
          state_d = ST_WR_MEM;
        end else if (hit) begin
          cpu_ready_o = 1'b1;
          cpu_rdata_o = rd_data;
          state_d     = ST_IDLE;
        end else begin
          state_d = ST_RD_MEM;
        end
      end
      ST_RD_MEM: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          cpu_ready_o = 1'b1;
          cpu_rdata_o = mem_rdata_i;
          fill_en     = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      ST_WR_MEM: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ack_i) begin
          cpu_ready_o = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign wr_en       = upd_en | fill_en;
  assign wr_data     = fill_en ? mem_rdata_i : wdata_q;

  wtc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (init_i),
    .idx_i       (a_idx),
    .wr_en_i     (wr_en),
    .set_valid_i (fill_en),
    .wr_tag_i    (a_tag),
    .wr_data_i   (wr_data),
    .rd_valid_o  (rd_valid),
    .rd_tag_o    (rd_tag),
    .rd_data_o   (rd_data)
  );

  wtc_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
    .valid_i  (rd_valid),
    .stored_i (rd_tag),
    .probe_i  (a_tag),
    .hit_o    (hit)
  );

  wtc_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lookup_i  (lookup),
    .hit_i     (hit),
    .hit_cnt_o (hit_cnt_o),
    .acc_cnt_o (acc_cnt_o)
  );
endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk #(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic              cpu_ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [CNT_W-1:0]  hit_cnt_o,
  input logic [CNT_W-1:0]  acc_cnt_o
);
  // R3: request and address hold until acknowledged
  p_mem_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R2: completion only answers a pending request
  p_ready_has_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> cpu_req_i);

  // R5: a write completes only through an acknowledged memory write
  p_write_through_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && cpu_we_i) |-> (mem_req_o && mem_we_o && mem_ack_i));

  // R9: lookup counter steps by zero or one
  p_acc_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((acc_cnt_o == $past(acc_cnt_o)) || (acc_cnt_o == $past(acc_cnt_o) + 1'b1)));

  // R9: a hit count step always comes with a lookup count step
  p_hit_with_acc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((hit_cnt_o == $past(hit_cnt_o)) ||
              ((hit_cnt_o == $past(hit_cnt_o) + 1'b1) && (acc_cnt_o == $past(acc_cnt_o) + 1'b1))));

  // R10: quiet outputs while reset is held
  always @(negedge clk_i) begin
    if (rst_ni === 1'b0) begin
      p_reset_quiet_r10: assert (!mem_req_o && !cpu_ready_o && hit_cnt_o == '0 && acc_cnt_o == '0);
    end
  end
endmodule

bind wtc_cache_top wtc_cache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_wtc_cache_top.sv
`timescale 1ns/1ps
module sim_wtc_cache_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0, req = 1'b0, we = 1'b0, ack = 1'b0;
  logic [14:0] addr = '0;
  logic [11:0] wdata = '0, mrdata = '0;
  logic [11:0] rdata, m_wdata;
  logic ready, m_req, m_we;
  logic [14:0] m_addr;
  logic [15:0] hit_cnt, acc_cnt;

  always #10 clk = ~clk;

  wtc_cache_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init),
    .cpu_req_i(req), .cpu_we_i(we), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_rdata_o(rdata), .cpu_ready_o(ready),
    .mem_req_o(m_req), .mem_we_o(m_we), .mem_addr_o(m_addr), .mem_wdata_o(m_wdata),
    .mem_rdata_i(mrdata), .mem_ack_i(ack),
    .hit_cnt_o(hit_cnt), .acc_cnt_o(acc_cnt)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit mvalid [512];
  int mtag [512];
  logic [11:0] mdata [512];
  logic [11:0] mem [int];
  int exp_hits = 0, exp_acc = 0;

  function automatic logic [11:0] mem_val(int a);
    if (mem.exists(a)) return mem[a];
    return 12'((a * 5 + 3) & 12'hFFF);
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // per-clock invariant: ready only while a request is raised
  always @(negedge clk) begin
    #5;
    if (rst_n && ready && !req) chk(1'b0, "R2", "ready without request", 1, 0);
  end

  task automatic access(bit w, logic [14:0] a, logic [11:0] d, bit init_at_ack);
    int idx = int'(a[8:0]);
    int tg  = int'(a[14:9]);
    bit hit = mvalid[idx] && (mtag[idx] == tg);
    int lat = int'(a) % 3;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #5 chk(!ready && !m_req, "R2", "idle accept cycle quiet", {ready, m_req}, 0);
    @(negedge clk); #5;
    exp_acc++;
    if (hit) exp_hits++;
    if (!w && hit) begin
      chk(ready === 1'b1, "R2", "read hit ready", ready, 1);
      chk(rdata === mdata[idx], "R2", "read hit data", rdata, mdata[idx]);
      chk(!m_req, "R2", "read hit no memory", m_req, 0);
    end else begin
      chk(!ready, "R1", "lookup not answered", ready, 0);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk); #5;
        chk(m_req && (m_we == w) && (m_addr == a) && !ready, w ? "R5" : "R3",
            "memory request held", {m_req, m_we, m_addr}, {1'b1, w, a});
        if (w) chk(m_wdata == d, "R5", "write data", m_wdata, d);
      end
      @(negedge clk);
      ack = 1'b1;
      mrdata = w ? 12'h0 : mem_val(int'(a));
      init = init_at_ack;
      #5;
      chk(m_req && (m_we == w) && (m_addr == a), w ? "R5" : "R3", "request at ack",
          {m_req, m_we, m_addr}, {1'b1, w, a});
      chk(ready === 1'b1, w ? "R5" : "R3", "ready at ack", ready, 1);
      if (w) chk(m_wdata == d, "R5", "write data at ack", m_wdata, d);
      else   chk(rdata === mrdata, "R3", "miss data", rdata, mrdata);
      if (w) begin
        mem[int'(a)] = d;
        if (hit) mdata[idx] = d;
      end else if (!init_at_ack) begin
        mvalid[idx] = 1'b1; mtag[idx] = tg; mdata[idx] = mrdata;
      end
      if (init_at_ack) foreach (mvalid[i]) mvalid[i] = 1'b0;
    end
    @(negedge clk);
    ack = 1'b0; req = 1'b0; init = 1'b0;
    #5;
    chk(acc_cnt == 16'(exp_acc), "R9", "access count", acc_cnt, exp_acc);
    chk(hit_cnt == 16'(exp_hits), "R9", "hit count", hit_cnt, exp_hits);
  endtask

  task automatic pulse_init();
    @(negedge clk); init = 1'b1;
    @(negedge clk); init = 1'b0;
    foreach (mvalid[i]) mvalid[i] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R0", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    foreach (mvalid[i]) mvalid[i] = 1'b0;
    mem[0] = 12'o1220;
    mem[15'o02000] = 12'o5670;
    repeat (3) @(negedge clk);
    #5 chk(!ready && !m_req && hit_cnt == 0 && acc_cnt == 0, "R10", "in reset", {ready, m_req}, 0);
    rst_n = 1'b1;
    @(negedge clk); #5;
    chk(!ready && !m_req && hit_cnt == 0 && acc_cnt == 0, "R10", "after reset", {ready, m_req}, 0);

    access(0, 15'o00000, 0, 0);           // R3 miss, fills tag 00 data 1220
    access(0, 15'o00000, 0, 0);           // R4 hit
    access(0, 15'o02000, 0, 0);           // R4 same index, tag 02 evicts
    access(0, 15'o00000, 0, 0);           // R4 evicted address misses
    access(0, 15'o02000, 0, 0);           // R1 tag 02 now misses again
    access(0, 15'o02000, 0, 0);           // R2 hit on 5670
    access(1, 15'o02000, 12'o4321, 0);    // R6 write hit
    access(0, 15'o02000, 0, 0);           // R6 read returns new word
    access(1, 15'h1234, 12'hABC, 0);      // R7 write miss
    access(0, 15'h1234, 0, 0);            // R7 still misses, returns written word
    access(0, 15'h1234, 0, 0);
    pulse_init();                         // R8 explicit clear
    access(0, 15'h1234, 0, 0);
    access(0, 15'h0155, 0, 1);            // R8 clear coincides with fill
    access(0, 15'h0155, 0, 0);            // must miss again
    access(0, 15'h0155, 0, 0);
    for (int i = 0; i < 24; i++)
      access(i % 4 == 3, 15'((i % 5) * 15'h0200 + (i % 3) * 7), 12'(i * 91), 0);
    summary();
  end
endmodule